// File: doc/BRIEF.md
# Multi-Bus MDIO Management Master

This block is a register-programmed management master for MDC/MDIO buses. One frame engine serves several physical bus pairs. The pairs are split into an internal group and an external group. Software fills in a parameter word, an address word and two rate-adjust words, then writes an opcode to the control register. The block then serialises a Clause 22 or Clause 45 management frame on the selected bus. During a read it collects the 16 returned data bits, and at the end of the transaction it sets a done flag.

The bus is chosen when the transaction starts and stays fixed until it ends. MDC is generated by a fractional accumulator that adds the programmed dividend each core cycle. The internal and external groups each have their own rate word. A lock-out bit in the scan-control register must be set before any transaction can start.

Top module: `mdio_mux_master`

## Requirements
- R1: After reset every register reads 0, and every MDC, MDIO output and output-enable pin is low.
- R2: The register offsets are: external rate word 0x000, internal rate word 0x004, scan control 0x008, parameter 0x23C, read data 0x240, address 0x244, control 0x248, status 0x24C.
  - The rate, scan, parameter and address registers read back the full 32 bits written.
  - Control reads back bits [1:0] of the last value written.
  - Read data carries the result in bits [15:0]; bits [31:16] read 0.
  - Status bit 0 is the done flag; the other status bits read 0.
- R3: Writing 1 or 2 to control has no effect on any bus pin unless scan-control bit 28 is 1. Without that bit, no MDC edge appears and done stays 0.
- R4: Writing 1 to control starts a write and writing 2 starts a read. Starting a transaction clears done, and done reads 1 once the transaction has finished. Writing 0 to control clears done.
- R5: Parameter fields: data [15:0], PHY address [20:16], Clause 45 select bit 21, bus number [24:22], internal-group select bit 25. A Clause 22 transaction sends 64 bits, MSB first, in this order:
  - 32 ones of preamble;
  - start 01;
  - opcode: 01 for a write, 10 for a read;
  - PHY address, 5 bits;
  - register address, 5 bits, taken from address bits [4:0];
  - turnaround: 10 for a write;
  - 16 data bits: the parameter data for a write.
- R6: With Clause 45 select set, two 64-bit frames are sent back to back, each with 32 ones of preamble, start 00, and PHY address followed by device address (address bits [20:16]):
  - first an address frame with opcode 00, turnaround 10 and data equal to address bits [15:0];
  - then a data frame with opcode 01 for a write (turnaround 10, parameter data) or 11 for a read.
- R7: During a read, the output enable of the selected bus is low for the last 18 bits of the data frame (turnaround and data). MDIO-in is sampled on each of the last 16 MDC rising edges, MSB first, into read data [15:0].
- R8: MDIO output changes only while MDC is low, and each bit is held across the MDC rising edge. Between transactions MDC, MDIO output and output enable are low.
- R9: Bus mapping:
  - With bit 25 set, bus number k drives pin index k.
  - With bit 25 clear, bus number k drives pin index N_INT+k.
  - Only the selected pin index ever shows MDC or output enable.
  - A bus number beyond its group gives no pin activity. The transaction still completes, and a read returns 0xFFFF.
- R10: Each rate word holds a divisor in [15:0] and a dividend in [31:16]. MDC changes level on every cycle where the running sum plus the dividend reaches the divisor; if the dividend is at least the divisor, MDC changes level every cycle. With dividend 1, MDC therefore has a period of 2×divisor core cycles. The internal group uses 0x004 and the external group uses 0x000.
- R11: An opcode written to control while a transaction is running does not restart or alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc_o | output | N_INT+N_EXT | Management clock per bus |
| mdio_o | output | N_INT+N_EXT | MDIO output value per bus |
| mdio_oe_o | output | N_INT+N_EXT | MDIO output enable per bus |
| mdio_i | input | N_INT+N_EXT | MDIO input per bus |

## Verification
Transactions are drawn at random over Clause 22 and Clause 45, read and write, internal and external buses, PHY and register addresses, data, and rate divisors. Every captured bit stream is compared bit by bit with a frame built from the field rules. Per-bus edge counts separate the effect of the mux selection from a correct frame shape. A responder returns a random data word, which catches sampling on the wrong edge or at the wrong bit offset.

Directed cases cover the following:
- the lock-out bit held clear;
- an opcode written mid-transaction;
- a bus number beyond its group;
- clearing done;
- two different divisors on the two groups, where the measured MDC period tells the rate words apart.

// File: rtl/mdio_mux_pkg.sv
package mdio_mux_pkg;
    localparam int IDW = 3;
    localparam logic [11:0] OFS_RATE_EXT = 12'h000;
    localparam logic [11:0] OFS_RATE_INT = 12'h004;
    localparam logic [11:0] OFS_SCAN     = 12'h008;
    localparam logic [11:0] OFS_PARAM    = 12'h23C;
    localparam logic [11:0] OFS_RDATA    = 12'h240;
    localparam logic [11:0] OFS_ADDR     = 12'h244;
    localparam logic [11:0] OFS_CTRL     = 12'h248;
    localparam logic [11:0] OFS_STAT     = 12'h24C;
    localparam int          OVR_BIT      = 28;
    localparam logic [31:0] CMD_WR       = 32'd1;
    localparam logic [31:0] CMD_RD       = 32'd2;

    typedef struct packed {
        logic [31:0]    rate_ext;
        logic [31:0]    rate_int;
        logic [31:0]    scan;
        logic [31:0]    param;
        logic [31:0]    addr;
        logic [1:0]     ctrl;
        logic           done;
        logic [15:0]    rdata;
        logic           sel_int;
        logic [IDW-1:0] sel_id;
        logic           op_rd;
    } regs_t;

    typedef struct packed {
        logic        busy;
        logic        mdc;
        logic        second;
        logic        rd;
        logic        c45;
        logic        done;
        logic [5:0]  bitn;
        logic [63:0] sh;
        logic [4:0]  phy;
        logic [4:0]  dreg;
        logic [15:0] wdata;
        logic [15:0] rdata;
    } eng_t;

    function automatic logic [63:0] mk_frame(input logic [1:0] st, input logic [1:0] op,
                                             input logic [4:0] pa, input logic [4:0] ra,
                                             input logic [1:0] ta, input logic [15:0] dat);
        return {32'hFFFF_FFFF, st, op, pa, ra, ta, dat};
    endfunction
endpackage

// File: rtl/mdio_ratediv.sv
module mdio_ratediv #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         tick_o
);
    logic [W:0] acc_d, acc_q, sum;

    always_comb begin
        sum    = acc_q + {1'b0, dividend_i};
        acc_d  = sum;
        tick_o = 1'b0;
        if (!en_i) begin
            acc_d = '0;
        end else if (dividend_i >= divisor_i) begin
            acc_d  = '0;
            tick_o = 1'b1;
        end else if (sum >= {1'b0, divisor_i}) begin
            acc_d  = sum - {1'b0, divisor_i};
            tick_o = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R10: the accumulator never holds a full divisor's worth
    p_acc_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && dividend_i < divisor_i) |-> (acc_q < {1'b0, divisor_i}));
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_mux_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        rd_i,
    input  logic        c45_i,
    input  logic [4:0]  phy_i,
    input  logic [4:0]  dreg_i,
    input  logic [15:0] addr_i,
    input  logic [15:0] wdata_i,
    input  logic        tick_i,
    input  logic        mdi_i,
    output logic        mdc_o,
    output logic        mdo_o,
    output logic        oe_o,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] rdata_o
);
    eng_t q, n;
    logic data_frame;

    assign data_frame = !q.c45 || q.second;
    assign mdc_o   = q.mdc;
    assign mdo_o   = q.busy & q.sh[63];
    assign oe_o    = q.busy & !(q.rd && data_frame && q.bitn >= 6'd46);
    assign busy_o  = q.busy;
    assign done_o  = q.done;
    assign rdata_o = q.rdata;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        if (!q.busy) begin
            n.mdc = 1'b0;
            if (start_i) begin
                n.busy   = 1'b1;
                n.second = 1'b0;
                n.bitn   = '0;
                n.rd     = rd_i;
                n.c45    = c45_i;
                n.phy    = phy_i;
                n.dreg   = dreg_i;
                n.wdata  = wdata_i;
                if (c45_i)
                    n.sh = mk_frame(2'b00, 2'b00, phy_i, dreg_i, 2'b10, addr_i);
                else if (rd_i)
                    n.sh = mk_frame(2'b01, 2'b10, phy_i, dreg_i, 2'b11, 16'h0000);
                else
                    n.sh = mk_frame(2'b01, 2'b01, phy_i, dreg_i, 2'b10, wdata_i);
            end
        end else if (tick_i) begin
            if (!q.mdc) begin
                n.mdc = 1'b1;
                if (q.rd && data_frame && q.bitn >= 6'd48)
                    n.rdata = {q.rdata[14:0], mdi_i};
            end else begin
                n.mdc = 1'b0;
                if (q.bitn == 6'd63) begin
                    if (q.c45 && !q.second) begin
                        n.second = 1'b1;
                        n.bitn   = '0;
                        n.sh     = q.rd ? mk_frame(2'b00, 2'b11, q.phy, q.dreg, 2'b11, 16'h0000)
                                        : mk_frame(2'b00, 2'b01, q.phy, q.dreg, 2'b10, q.wdata);
                    end else begin
                        n.busy = 1'b0;
                        n.done = 1'b1;
                    end
                end else begin
                    n.bitn = q.bitn + 6'd1;
                    n.sh   = {q.sh[62:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    // R8: a bit is held while MDC stays high
    p_mdo_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_o && $past(mdc_o)) |-> $stable(mdo_o));
    // R8: idle lines are quiet
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mdc_o && !oe_o && !mdo_o));
    // R4: completion only follows a running transaction
    p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $fell(busy_o));
endmodule

// File: rtl/mdio_mux_master.sv
module mdio_mux_master
    import mdio_mux_pkg::*;
#(
    parameter int N_INT = 2,
    parameter int N_EXT = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [11:0]            reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    output logic [N_INT+N_EXT-1:0] mdc_o,
    output logic [N_INT+N_EXT-1:0] mdio_o,
    output logic [N_INT+N_EXT-1:0] mdio_oe_o,
    input  logic [N_INT+N_EXT-1:0] mdio_i
);
    localparam int NB = N_INT + N_EXT;

    regs_t       q, n;
    logic        start;
    logic        tick, mdi_sel;
    logic        eng_mdc, eng_mdo, eng_oe, eng_busy, eng_done;
    logic [15:0] eng_rdata;
    logic [NB-1:0] hit;
    logic [15:0] dividend, divisor;

    always_comb begin
        n     = q;
        start = 1'b0;
        if (eng_done) begin
            n.done = 1'b1;
            if (q.op_rd) n.rdata = eng_rdata;
        end
        if (reg_we) begin
            case (reg_addr)
                OFS_RATE_EXT: n.rate_ext = reg_wdata;
                OFS_RATE_INT: n.rate_int = reg_wdata;
                OFS_SCAN:     n.scan     = reg_wdata;
                OFS_PARAM:    n.param    = reg_wdata;
                OFS_ADDR:     n.addr     = reg_wdata;
                OFS_CTRL: begin
                    n.ctrl = reg_wdata[1:0];
                    if (reg_wdata == 32'd0) begin
                        n.done = 1'b0;
                    end else if ((reg_wdata == CMD_WR || reg_wdata == CMD_RD)
                                 && q.scan[OVR_BIT] && !eng_busy) begin
                        start     = 1'b1;
                        n.done    = 1'b0;
                        n.sel_int = q.param[25];
                        n.sel_id  = q.param[24:22];
                        n.op_rd   = (reg_wdata == CMD_RD);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        case (reg_addr)
            OFS_RATE_EXT: reg_rdata = q.rate_ext;
            OFS_RATE_INT: reg_rdata = q.rate_int;
            OFS_SCAN:     reg_rdata = q.scan;
            OFS_PARAM:    reg_rdata = q.param;
            OFS_RDATA:    reg_rdata = {16'h0000, q.rdata};
            OFS_ADDR:     reg_rdata = q.addr;
            OFS_CTRL:     reg_rdata = {30'd0, q.ctrl};
            OFS_STAT:     reg_rdata = {31'd0, q.done};
            default:      reg_rdata = 32'd0;
        endcase
    end

    assign dividend = q.sel_int ? q.rate_int[31:16] : q.rate_ext[31:16];
    assign divisor  = q.sel_int ? q.rate_int[15:0]  : q.rate_ext[15:0];

    mdio_ratediv #(.W(16)) u_div (
        .clk(clk), .rst_n(rst_n), .en_i(eng_busy),
        .dividend_i(dividend), .divisor_i(divisor), .tick_o(tick)
    );

    mdio_frame_eng u_eng (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rd_i(reg_wdata == CMD_RD),
        .c45_i(q.param[21]), .phy_i(q.param[20:16]),
        .dreg_i(q.param[21] ? q.addr[20:16] : q.addr[4:0]),
        .addr_i(q.addr[15:0]), .wdata_i(q.param[15:0]),
        .tick_i(tick), .mdi_i(mdi_sel),
        .mdc_o(eng_mdc), .mdo_o(eng_mdo), .oe_o(eng_oe),
        .busy_o(eng_busy), .done_o(eng_done), .rdata_o(eng_rdata)
    );

    for (genvar i = 0; i < NB; i++) begin : g_bus
        localparam bit IS_INT = (i < N_INT);
        localparam int LID    = IS_INT ? i : i - N_INT;
        assign hit[i]       = (q.sel_int == IS_INT) && (q.sel_id == LID[IDW-1:0]);
        assign mdc_o[i]     = hit[i] & eng_mdc;
        assign mdio_o[i]    = hit[i] & eng_mdo;
        assign mdio_oe_o[i] = hit[i] & eng_oe;
    end

    always_comb begin
        mdi_sel = 1'b1;
        for (int i = 0; i < NB; i++)
            if (hit[i]) mdi_sel = mdio_i[i];
    end

    // R9: at most one bus is ever active
    p_one_mdc_r9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mdc_o));
    p_one_oe_r9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mdio_oe_o));
    // R3: no start while the lock-out bit is clear
    p_lockout_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_CTRL && !q.scan[OVR_BIT] && !eng_busy) |=> !eng_busy);
    // R4: clearing control clears the done flag
    p_clear_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_CTRL && reg_wdata == 32'd0) |=> (reg_addr != OFS_STAT || reg_rdata == 32'd0));
    // R11: the selected bus is frozen while running
    p_sel_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && $past(eng_busy)) |-> $stable(hit));
endmodule

// File: tb/mdio_mux_master_tb.sv
module mdio_mux_master_tb;
    localparam int NB = 4;
    localparam int NI = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NB-1:0] mdc_o, mdio_o, mdio_oe_o;
    logic [NB-1:0] mdio_i;

    int checks = 0, errors = 0;
    bit finished = 0;

    mdio_mux_master #(.N_INT(2), .N_EXT(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc_o(mdc_o),
        .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
    );

    always #10 clk = ~clk;

    // bus monitor and responder
    int          cyc = 0;
    int          rc [NB];
    int          fc [NB];
    int          last_rise [NB];
    int          gap [NB];
    logic [127:0] cap_mdo [NB];
    logic [127:0] cap_oe [NB];
    logic [NB-1:0] prev_mdc = '0, prev_mdo = '0;
    int          glitches = 0;
    logic [15:0] resp = 16'h0;

    initial begin
        for (int i = 0; i < NB; i++) begin
            rc[i] = 0; fc[i] = 0; last_rise[i] = 0; gap[i] = 0;
            cap_mdo[i] = '0; cap_oe[i] = '0;
        end
        mdio_i = '1;
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        for (int i = 0; i < NB; i++) begin
            if (mdc_o[i] && prev_mdc[i] && mdio_o[i] != prev_mdo[i]) glitches++;
            if (mdc_o[i] && !prev_mdc[i]) begin
                cap_mdo[i][rc[i] % 128] = mdio_o[i];
                cap_oe[i][rc[i] % 128]  = mdio_oe_o[i];
                gap[i] = cyc - last_rise[i];
                last_rise[i] = cyc;
                rc[i]++;
            end
            if (!mdc_o[i] && prev_mdc[i]) begin
                int idx;
                fc[i]++;
                idx = fc[i] % 64;
                mdio_i[i] = (idx >= 48) ? resp[63 - idx] : 1'b1;
            end
        end
        prev_mdc = mdc_o;
        prev_mdo = mdio_o;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [127:0] exp_bits(input bit c45, input bit rdop, input logic [4:0] phy,
                                              input logic [15:0] ra, input logic [4:0] dev,
                                              input logic [15:0] wd);
        logic [63:0] f0, f1;
        if (c45) begin
            f0 = {32'hFFFF_FFFF, 2'b00, 2'b00, phy, dev, 2'b10, ra};
            f1 = {32'hFFFF_FFFF, 2'b00, rdop ? 2'b11 : 2'b01, phy, dev, 2'b10, wd};
        end else begin
            f0 = {32'hFFFF_FFFF, 2'b01, rdop ? 2'b10 : 2'b01, phy, ra[4:0], 2'b10, wd};
            f1 = '0;
        end
        return {f0, f1};
    endfunction

    task automatic run_txn(input bit c45, input bit rdop, input bit isint, input logic [2:0] id,
                           input logic [4:0] phy, input logic [15:0] ra, input logic [4:0] dev,
                           input logic [15:0] wd, input logic [15:0] rsp, input bit poke,
                           input int exp_gap);
        int eb, nbits, base;
        int rbase [NB];
        int g0;
        logic [31:0] v;
        logic [127:0] e;
        int bad_bits, bad_oe;
        eb = (id < NI) ? (isint ? int'(id) : NI + int'(id)) : -1;
        nbits = c45 ? 128 : 64;
        resp = rsp;
        for (int i = 0; i < NB; i++) rbase[i] = rc[i];
        g0 = glitches;
        wr(12'h23C, {6'd0, isint, id, c45, phy, wd});
        wr(12'h244, c45 ? {11'd0, dev, ra} : {16'd0, ra});
        wr(12'h248, rdop ? 32'd2 : 32'd1);
        if (poke) begin
            repeat (10) @(negedge clk);
            wr(12'h248, rdop ? 32'd1 : 32'd2);
        end
        v = 0;
        for (int t = 0; t < 5000 && v[0] == 1'b0; t++) begin
            @(negedge clk);
            rd(12'h24C, v);
        end
        chk(v == 32'd1, "R4 done after transaction", v, 1);
        for (int i = 0; i < NB; i++)
            chk((rc[i] - rbase[i]) == (i == eb ? nbits : 0), "R9 MDC edges per bus", rc[i] - rbase[i], i == eb ? nbits : 0);
        chk(glitches == g0, "R8 MDIO steady while MDC high", glitches - g0, 0);
        if (eb >= 0) begin
            e = exp_bits(c45, rdop, phy, ra, dev, wd);
            base = rbase[eb];
            bad_bits = 0; bad_oe = 0;
            for (int k = 0; k < nbits; k++) begin
                int j;
                bit dfr, eoe;
                j = k % 64;
                dfr = !c45 || (k >= 64);
                eoe = !(rdop && dfr && j >= 46);
                if (cap_oe[eb][(base + k) % 128] != eoe) bad_oe++;
                if (eoe && cap_mdo[eb][(base + k) % 128] != e[127 - k]) bad_bits++;
            end
            chk(bad_bits == 0, c45 ? "R6 Clause 45 frame bits" : "R5 Clause 22 frame bits", bad_bits, 0);
            chk(bad_oe == 0, "R7 output enable pattern", bad_oe, 0);
            if (exp_gap > 0) chk(gap[eb] == exp_gap, "R10 MDC period", gap[eb], exp_gap);
        end
        if (rdop) begin
            rd(12'h240, v);
            chk(v == {16'd0, (eb >= 0) ? rsp : 16'hFFFF}, "R7 read data", v, (eb >= 0) ? rsp : 16'hFFFF);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [11:0] offs [8];
        int r0;
        offs = '{12'h000, 12'h004, 12'h008, 12'h23C, 12'h240, 12'h244, 12'h248, 12'h24C};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd(offs[i], v);
            chk(v == 0, "R1 register reset value", v, 0);
        end
        chk(mdc_o == 0 && mdio_oe_o == 0 && mdio_o == 0, "R1 pins low after reset", {mdc_o, mdio_oe_o, mdio_o}, 0);

        // R2 register readback
        wr(12'h000, 32'h0001_0003);
        wr(12'h004, 32'h0001_0002);
        wr(12'h008, 32'h0000_00A5);
        wr(12'h23C, 32'hDEAD_BEEF);
        wr(12'h244, 32'h1234_5678);
        rd(12'h000, v); chk(v == 32'h0001_0003, "R2 external rate readback", v, 32'h0001_0003);
        rd(12'h004, v); chk(v == 32'h0001_0002, "R2 internal rate readback", v, 32'h0001_0002);
        rd(12'h008, v); chk(v == 32'h0000_00A5, "R2 scan readback", v, 32'h0000_00A5);
        rd(12'h23C, v); chk(v == 32'hDEAD_BEEF, "R2 parameter readback", v, 32'hDEAD_BEEF);
        rd(12'h244, v); chk(v == 32'h1234_5678, "R2 address readback", v, 32'h1234_5678);

        // R3 lock-out: override bit clear
        r0 = rc[0] + rc[1] + rc[2] + rc[3];
        wr(12'h23C, 32'h0200_0000);
        wr(12'h248, 32'd1);
        rd(12'h248, v); chk(v == 32'd1, "R2 control readback", v, 1);
        repeat (60) @(negedge clk);
        rd(12'h24C, v); chk(v == 0, "R3 done stays low when locked out", v, 0);
        chk((rc[0] + rc[1] + rc[2] + rc[3]) == r0, "R3 no MDC edge when locked out", rc[0] + rc[1] + rc[2] + rc[3] - r0, 0);
        wr(12'h248, 32'd0);

        wr(12'h008, 32'h1000_0000);
        // R10 internal divisor 2 vs external divisor 3
        run_txn(0, 0, 1, 3'd0, 5'h11, 16'h0005, 5'h0, 16'hA55A, 16'h0, 0, 4);
        run_txn(0, 1, 0, 3'd1, 5'h03, 16'h001F, 5'h0, 16'h0, 16'hC3A1, 0, 6);
        // R6 Clause 45 on both groups
        run_txn(1, 0, 0, 3'd0, 5'h1E, 16'hBEEF, 5'h07, 16'h1357, 16'h0, 0, 6);
        run_txn(1, 1, 1, 3'd1, 5'h01, 16'h8001, 5'h1F, 16'h0, 16'h5AF0, 0, 4);
        // R11 opcode while busy is ignored
        run_txn(0, 0, 1, 3'd1, 5'h0A, 16'h0012, 5'h0, 16'hF00F, 16'h0, 1, 4);
        // R9 bus number beyond the group
        run_txn(0, 1, 1, 3'd5, 5'h02, 16'h0003, 5'h0, 16'h0, 16'h1234, 0, 0);
        // R4 clearing control clears done
        wr(12'h248, 32'd0);
        rd(12'h24C, v); chk(v == 0, "R4 done cleared by writing 0", v, 0);
        chk(mdc_o == 0 && mdio_oe_o == 0, "R8 pins idle between transactions", {mdc_o, mdio_oe_o}, 0);

        // random mix
        void'($urandom(32'd2024));
        for (int it = 0; it < 12; it++) begin
            int d;
            logic [2:0] id;
            bit isint;
            d = 1 + ($urandom % 3);
            isint = $urandom % 2;
            id = 3'($urandom % 2);
            wr(12'h000, {16'd1, 16'(d)});
            wr(12'h004, {16'd1, 16'(d)});
            run_txn($urandom % 2, $urandom % 2, isint, id, 5'($urandom), 16'($urandom),
                    5'($urandom), 16'($urandom), 16'($urandom), 0, 2 * d);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule